// File: doc/BRIEF.md
# Burst Bus Initiator for a Multiplexed Address/Data Bus

This block is the master side of a synchronous shared bus. Address and data use the same lines, and the framing and ready strobes are active low. A local client hands it one command: read or write, a start address and a word count. The block then requests the bus and waits for a grant. It drives one address cycle and streams the data words. A word moves on any rising edge where both the initiator ready and the target ready strobes are low. Either side can stall by holding its ready strobe high.

The frame strobe goes high while the final word is still pending, so the target knows which word is the last. After the final word the block drives frame and initiator-ready high for one cycle and then releases every line. The target can end the burst early with its stop strobe. If it stops while still selected, the block releases the bus, re-arbitrates and continues from the first word that did not move. If it stops without being selected, the command ends with an error. If the grant is taken away during a burst, the block makes the next word its last one, then requests the bus again for the remaining words. On reads the shared address/data lines go undriven from the first data cycle on, which leaves the turnaround cycle for the target.

Top module: `pbi_initiator`

## Requirements
- R1: After reset the block drives no bus line (all output enables low), holds its bus request high and reports `cmd_ready` high.
- R2: A command offered with a word count of zero is ignored: no bus request and no address cycle follow, and `cmd_ready` stays high.
- R3: An accepted command raises the bus request (low). After the grant is sampled low, one address cycle follows with frame low, initiator-ready not driven, the address on `ad_o` and the command code on `cbe_o`: 4'b0110 for read, 4'b0111 for write.
- R4: A data word transfers only on a rising edge where initiator-ready, target-ready and device-select are all low. Each transfer advances the address by DW/8 bytes and pulses `rd_valid` (read, data on `rd_data`) or `wr_take` (write, `wr_data` on the bus).
- R5: Frame is held low in data cycles while more than one word remains and goes high in the cycle whose transfer is the last of the phase. Once high during a phase, it does not go low again in that phase.
- R6: The initiator asserts its ready strobe only when `ini_rdy` is high. Once asserted, it keeps it asserted until a transfer or a stop.
- R7: On reads, `ad_o` is undriven from the first data cycle onward. On writes, `ad_o` is driven with the write data during data cycles.
- R8: The cycle after the final transfer or a stop drives frame and initiator-ready high. The cycle after that releases every line. `done` pulses in that high-drive cycle.
- R9: Stop with device-select low ends the phase after any word that moves with it. The block then re-arbitrates and issues a new address cycle at the first untransferred address, until all words have moved.
- R10: Stop with device-select high is a target abort: the command ends with `done` and `err` both pulsed, and no further address cycle is issued.
- R11: If the grant is sampled high during an address or data cycle, frame goes high from the next cycle. After the next transfer the block re-requests the bus for the remaining words.
- R12: The byte-enable lanes `cbe_o` read 4'b0000 (all lanes enabled) in every data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command offered |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | DW | Byte start address |
| req_len | input | LW | Number of words (0 ignored) |
| cmd_ready | output | 1 | Idle; a command is accepted this cycle |
| wr_data | input | DW | Write word, held until `wr_take` |
| wr_take | output | 1 | Current write word transferred |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | `rd_data` transferred this edge |
| ini_rdy | input | 1 | Client allows the initiator ready strobe |
| done | output | 1 | Command finished |
| err | output | 1 | Command ended by target abort |
| bus_req_n_o | output | 1 | Bus request, active low |
| gnt_n_i | input | 1 | Bus grant, active low |
| frame_n_o | output | 1 | Frame strobe value |
| frame_oe | output | 1 | Frame strobe drive enable |
| irdy_n_o | output | 1 | Initiator ready value |
| irdy_oe | output | 1 | Initiator ready drive enable |
| ad_o | output | DW | Address/data output value |
| ad_oe | output | 1 | Address/data drive enable |
| ad_i | input | DW | Address/data as seen on the bus |
| cbe_o | output | 4 | Command / byte-enable lanes |
| cbe_oe | output | 1 | Command / byte-enable drive enable |
| trdy_n_i | input | 1 | Target ready, active low |
| stop_n_i | input | 1 | Target stop, active low |
| devsel_n_i | input | 1 | Target selected, active low |

## Verification
The hardest case to reach from the ports is the grant being withdrawn in the middle of a burst. The grant has to go high in exactly the cycle when a word has moved but more than one word still remains, so that the phase is cut short and a second address cycle results. The bench's target model counts transferred words and raises the grant line on the falling edge after the first one. It holds the grant off for a few cycles so that the block must wait in request, then expects the second address cycle at start plus three words. Retry and abort come from the same target model, which asserts stop at a chosen word index across a sweep of wait patterns on both sides.

// File: rtl/pbi_pkg.sv
package pbi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_TURN
  } pbi_state_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] BE_ALL     = 4'b0000;
endpackage

// File: rtl/pbi_walker.sv
// Tracks the next bus address and the count of words still to move.
module pbi_walker #(
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [DW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  output logic [DW-1:0] cur_addr,
  output logic          last_one,
  output logic          none_left
);
  localparam int STEP = DW / 8;

  logic [DW-1:0] addr_q, addr_d;
  logic [LW-1:0] rem_q, rem_d;

  always_comb begin
    addr_d = addr_q;
    rem_d  = rem_q;
    if (load) begin
      addr_d = ld_addr;
      rem_d  = ld_len;
    end else if (adv) begin
      addr_d = addr_q + DW'(STEP);
      rem_d  = rem_q - LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load || adv) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  assign cur_addr  = addr_q;
  assign last_one  = (rem_q == LW'(1));
  assign none_left = (rem_q == '0);
endmodule

// File: rtl/pbi_fsm.sv
// Transaction sequencer: arbitration, address, data, release.
module pbi_fsm
  import pbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       gnt_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic       devsel_n,
  input  logic       ini_rdy,
  input  logic       last_one,
  input  logic       none_left,
  output pbi_state_e state_q,
  output logic       irdy_act,
  output logic       xfer,
  output logic       frame_last,
  output logic       abort_q
);
  pbi_state_e state_d;
  logic drop_q, drop_d;
  logic hold_q, hold_d;
  logic abort_d;
  logic in_data;

  assign in_data    = (state_q == S_DATA);
  assign irdy_act   = in_data && (ini_rdy || hold_q);
  assign xfer       = irdy_act && !trdy_n && !devsel_n;
  assign frame_last = last_one || drop_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = S_REQ;
      S_REQ:  if (!gnt_n) state_d = S_ADDR;
      S_ADDR: state_d = S_DATA;
      S_DATA: if (!stop_n || (xfer && frame_last)) state_d = S_TURN;
      S_TURN: state_d = (abort_q || none_left) ? S_IDLE : S_REQ;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    drop_d  = (state_q == S_ADDR || in_data) ? (drop_q || gnt_n) : 1'b0;
    hold_d  = irdy_act && !xfer && stop_n;
    abort_d = abort_q;
    if (in_data && !stop_n && devsel_n) abort_d = 1'b1;
    else if (state_q == S_TURN)         abort_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      drop_q  <= 1'b0;
      hold_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      drop_q  <= drop_d;
      hold_q  <= hold_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/pbi_initiator.sv
module pbi_initiator
  import pbi_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          cmd_ready,
  input  logic [DW-1:0] wr_data,
  output logic          wr_take,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          ini_rdy,
  output logic          done,
  output logic          err,
  output logic          bus_req_n_o,
  input  logic          gnt_n_i,
  output logic          frame_n_o,
  output logic          frame_oe,
  output logic          irdy_n_o,
  output logic          irdy_oe,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic [3:0]    cbe_o,
  output logic          cbe_oe,
  input  logic          trdy_n_i,
  input  logic          stop_n_i,
  input  logic          devsel_n_i
);
  logic [1:0]    rsync_q;
  logic          rst_core_n;
  logic          start;
  logic          wr_q;
  logic          irdy_act, xfer, frame_last, abort_q;
  logic          last_one, none_left;
  logic [DW-1:0] cur_addr;
  pbi_state_e    state_q;
  logic          st_addr, st_data, st_turn;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  assign cmd_ready = (state_q == S_IDLE);
  assign start     = cmd_ready && req_valid && (req_len != '0);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  wr_q <= 1'b0;
    else if (start)   wr_q <= req_write;
  end

  pbi_walker #(.DW(DW), .LW(LW)) u_walker (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (start),
    .adv       (xfer),
    .ld_addr   (req_addr),
    .ld_len    (req_len),
    .cur_addr  (cur_addr),
    .last_one  (last_one),
    .none_left (none_left)
  );

  pbi_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .gnt_n      (gnt_n_i),
    .trdy_n     (trdy_n_i),
    .stop_n     (stop_n_i),
    .devsel_n   (devsel_n_i),
    .ini_rdy    (ini_rdy),
    .last_one   (last_one),
    .none_left  (none_left),
    .state_q    (state_q),
    .irdy_act   (irdy_act),
    .xfer       (xfer),
    .frame_last (frame_last),
    .abort_q    (abort_q)
  );

  assign st_addr = (state_q == S_ADDR);
  assign st_data = (state_q == S_DATA);
  assign st_turn = (state_q == S_TURN);

  assign bus_req_n_o = !(state_q == S_REQ);
  assign frame_oe    = st_addr || st_data || st_turn;
  assign frame_n_o   = !(st_addr || (st_data && !frame_last));
  assign irdy_oe     = st_data || st_turn;
  assign irdy_n_o    = !irdy_act;
  assign ad_oe       = st_addr || (st_data && wr_q);
  assign ad_o        = st_addr ? cur_addr : wr_data;
  assign cbe_oe      = st_addr || st_data;
  assign cbe_o       = st_addr ? (wr_q ? CMD_MEM_WR : CMD_MEM_RD) : BE_ALL;

  assign wr_take  = xfer && wr_q;
  assign rd_valid = xfer && !wr_q;
  assign rd_data  = ad_i;
  assign done     = st_turn && (abort_q || none_left);
  assign err      = st_turn && abort_q;
endmodule

// File: rtl/pbi_initiator_chk.sv
module pbi_initiator_chk
  import pbi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n_o,
  input logic       frame_oe,
  input logic       irdy_n_o,
  input logic       irdy_oe,
  input logic       ad_oe,
  input logic [3:0] cbe_o,
  input logic       cbe_oe,
  input logic       trdy_n_i,
  input logic       stop_n_i,
  input logic       devsel_n_i,
  input logic       gnt_n_i,
  input logic       rd_valid,
  input logic       wr_take,
  input logic       done
);
  logic addr_cyc;
  assign addr_cyc = frame_oe && !frame_n_o && !irdy_oe;

  assert_addr_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cyc |-> $past(!gnt_n_i));

  assert_xfer_needs_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid || wr_take) |-> (irdy_oe && !irdy_n_o && !trdy_n_i));

  assert_frame_stays_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_oe && frame_n_o && irdy_oe && !irdy_n_o) |=> (!frame_oe || frame_n_o));

  assert_irdy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && !irdy_n_o && trdy_n_i && stop_n_i) |=> (irdy_oe && !irdy_n_o));

  assert_read_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && cbe_o == CMD_MEM_RD) |=> !ad_oe);

  assert_final_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irdy_oe && !irdy_n_o && frame_n_o && !trdy_n_i && !devsel_n_i && stop_n_i)
      |=> (frame_oe && frame_n_o && irdy_oe && irdy_n_o));

  assert_done_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!frame_oe && !irdy_oe && !ad_oe && !cbe_oe));

  assert_be_enabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cbe_oe && irdy_oe) |-> (cbe_o == BE_ALL));
endmodule

bind pbi_initiator pbi_initiator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_n_o  (frame_n_o),
  .frame_oe   (frame_oe),
  .irdy_n_o   (irdy_n_o),
  .irdy_oe    (irdy_oe),
  .ad_oe      (ad_oe),
  .cbe_o      (cbe_o),
  .cbe_oe     (cbe_oe),
  .trdy_n_i   (trdy_n_i),
  .stop_n_i   (stop_n_i),
  .devsel_n_i (devsel_n_i),
  .gnt_n_i    (gnt_n_i),
  .rd_valid   (rd_valid),
  .wr_take    (wr_take),
  .done       (done)
);

// File: tb/test_pbi_initiator.sv
`timescale 1ns/1ps
module test_pbi_initiator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [7:0]  req_len;
  logic        cmd_ready, wr_take, rd_valid, done, err;
  logic [31:0] wr_data, rd_data, ad_o, ad_i;
  logic        ini_rdy;
  logic        bus_req_n_o, gnt_n_i, frame_n_o, frame_oe, irdy_n_o, irdy_oe, ad_oe;
  logic [3:0]  cbe_o;
  logic        cbe_oe, trdy_n_i, stop_n_i, devsel_n_i;

  always #5 clk = ~clk;

  pbi_initiator i_pbi_initiator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .cmd_ready(cmd_ready),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .ini_rdy(ini_rdy), .done(done), .err(err), .bus_req_n_o(bus_req_n_o),
    .gnt_n_i(gnt_n_i), .frame_n_o(frame_n_o), .frame_oe(frame_oe),
    .irdy_n_o(irdy_n_o), .irdy_oe(irdy_oe), .ad_o(ad_o), .ad_oe(ad_oe),
    .ad_i(ad_i), .cbe_o(cbe_o), .cbe_oe(cbe_oe), .trdy_n_i(trdy_n_i),
    .stop_n_i(stop_n_i), .devsel_n_i(devsel_n_i)
  );

  int n_checks = 0, n_fail = 0, cyc = 0, cyc_n = 0;

  function automatic logic [31:0] mpat(int i);
    return 32'h5000_0000 + 32'(i) * 32'd13;
  endfunction
  function automatic logic [31:0] wpat(int i);
    return 32'hC0DE_0000 + 32'(i) * 32'd7;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // target model state and knobs
  logic [31:0] mem [64];
  logic        t_act, t_rd;
  logic [5:0]  t_addr;
  int          t_wait, k_wait, k_ip, k_stop_at, op_base, op_len;
  bit          k_abort, op_plain, stop_fired, gblock;
  int          total_words, nphase, taken, rd_cnt, rd_err, done_cnt, err_cnt;
  int          fr_err, be_err, ta_err;
  logic [31:0] phase_addr [4];
  logic        stop_now, xfer_seen;

  assign stop_now   = t_act && !stop_fired && (k_stop_at >= 0) && (total_words == k_stop_at);
  assign devsel_n_i = !(t_act && !k_abort);
  assign trdy_n_i   = !(t_act && !k_abort && t_wait == 0 && !stop_now);
  assign stop_n_i   = !(t_act && (k_abort || stop_now));
  assign ad_i       = mem[t_addr];
  assign gnt_n_i    = gblock;
  assign wr_data    = wpat(taken);
  assign xfer_seen  = irdy_oe && !irdy_n_o && !trdy_n_i && !devsel_n_i;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_cnt <= done_cnt + 1;
    if (err)  err_cnt  <= err_cnt + 1;
    if (wr_take) taken <= taken + 1;
    if (cbe_oe && irdy_oe && cbe_o != 4'b0000) be_err <= be_err + 1;       // R12
    if (irdy_oe && !irdy_n_o && t_rd && ad_oe) ta_err <= ta_err + 1;        // R7 read
    if (wr_take && !ad_oe) ta_err <= ta_err + 1;                            // R7 write
    if (rd_valid) begin
      if (rd_data !== mpat(op_base + rd_cnt)) rd_err <= rd_err + 1;
      rd_cnt <= rd_cnt + 1;
    end
    if (frame_oe && !frame_n_o && !irdy_oe) begin
      if (nphase < 4) phase_addr[nphase] <= ad_o;
      nphase <= nphase + 1;
      t_act  <= 1'b1;
      t_addr <= ad_o[7:2];
      t_rd   <= (cbe_o == 4'b0110);
      t_wait <= (cbe_o == 4'b0110 && k_wait == 0) ? 1 : k_wait;
    end else if (t_act) begin
      if (irdy_oe && irdy_n_o && frame_n_o && !cbe_oe) t_act <= 1'b0;
      else begin
        if (stop_now) stop_fired <= 1'b1;
        if (xfer_seen) begin
          if (!t_rd) mem[t_addr] <= ad_o;
          if (op_plain && (frame_n_o != (total_words == op_len - 1))) fr_err <= fr_err + 1;
          t_addr      <= t_addr + 6'd1;
          total_words <= total_words + 1;
          t_wait      <= k_wait;
        end else if (t_wait > 0) t_wait <= t_wait - 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc_n  <= cyc_n + 1;
    ini_rdy <= (k_ip == 0) || ((cyc_n % (k_ip + 1)) != 0);
  end

  task automatic run_op(input bit wr, input int base, input int len, input int kw,
                        input int kip, input int kstop, input bit kab, input bit kdrop);
    int waited, exp_words, exp_ph, bad, dropped_at;
    @(negedge clk);
    k_wait = kw; k_ip = kip; k_stop_at = kstop; k_abort = kab;
    op_base = base; op_len = len; op_plain = (kstop < 0) && !kdrop && !kab;
    total_words = 0; nphase = 0; stop_fired = 0; taken = 0; rd_cnt = 0; rd_err = 0;
    done_cnt = 0; err_cnt = 0; fr_err = 0; be_err = 0; ta_err = 0; t_rd = 0;
    for (int i = 0; i < 64; i++) mem[i] = mpat(i);
    req_valid = 1'b1; req_write = wr; req_addr = 32'(base * 4); req_len = 8'(len);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0; dropped_at = -1;
    while (done_cnt == 0 && waited < 400) begin
      @(negedge clk);
      waited++;
      if (kdrop && dropped_at < 0 && total_words >= 1) begin gblock = 1'b1; dropped_at = waited; end
      if (kdrop && dropped_at >= 0 && waited == dropped_at + 3) gblock = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    exp_words = kab ? 0 : len;
    exp_ph = 1 + ((kstop >= 0 && kstop < len && !kab) ? 1 : 0) + (kdrop ? 1 : 0);
    check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    check(err_cnt == (kab ? 1 : 0), kab ? "R10 err on abort" : "R10 no err", err_cnt, kab ? 1 : 0);
    check(total_words == exp_words, "R4 words moved", total_words, exp_words);
    check(phase_addr[0] == 32'(base * 4), "R3 first address", int'(phase_addr[0]), base * 4);
    check(nphase == exp_ph, "R9/R11 address cycles", nphase, exp_ph);
    if (kstop >= 0 && !kab)
      check(phase_addr[1] == 32'((base + kstop) * 4), "R9 retry address", int'(phase_addr[1]), (base + kstop) * 4);
    if (kdrop)
      check(phase_addr[1] == 32'((base + 3) * 4), "R11 regrant address", int'(phase_addr[1]), (base + 3) * 4);
    if (wr) begin
      bad = 0;
      for (int i = 0; i < 64; i++)
        if (mem[i] !== ((i >= base && i < base + exp_words) ? wpat(i - base) : mpat(i))) bad++;
      check(bad == 0, kip > 0 ? "R6 write data with initiator waits" : "R4 write data", bad, 0);
    end else begin
      check(rd_cnt == exp_words && rd_err == 0,
            kip > 0 ? "R6 read data with initiator waits" : "R4 read data", rd_err, 0);
    end
    if (op_plain) check(fr_err == 0, "R5 frame high on last word only", fr_err, 0);
    check(ta_err == 0, "R7 address/data drive", ta_err, 0);
    check(be_err == 0, "R12 byte enables", be_err, 0);
    check(!frame_oe && !irdy_oe && !ad_oe && cmd_ready && bus_req_n_o,
          "R8 lines released", int'(frame_oe) + int'(irdy_oe) + int'(ad_oe), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    gblock = 1'b0; t_act = 1'b0; t_rd = 1'b0; t_addr = '0; t_wait = 0;
    k_wait = 0; k_ip = 0; k_stop_at = -1; k_abort = 0; op_base = 0; op_len = 1; op_plain = 0;
    stop_fired = 0; total_words = 0; nphase = 0; taken = 0; rd_cnt = 0; rd_err = 0;
    done_cnt = 0; err_cnt = 0; fr_err = 0; be_err = 0; ta_err = 0; ini_rdy = 1'b1;
    for (int i = 0; i < 64; i++) mem[i] = mpat(i);
    repeat (4) @(negedge clk);
    check(!frame_oe && !irdy_oe && !ad_oe && !cbe_oe, "R1 no drive in reset",
          int'(frame_oe) + int'(irdy_oe) + int'(ad_oe) + int'(cbe_oe), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cmd_ready && bus_req_n_o, "R1 idle after reset", int'(cmd_ready), 1);

    // R2: zero-length command
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h40; req_len = 8'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    check(bus_req_n_o && cmd_ready && nphase == 0, "R2 zero length ignored", nphase, 0);

    // main sweep
    for (int wr = 0; wr < 2; wr++)
      for (int len = 1; len <= 5; len++)
        for (int kw = 0; kw < 3; kw++)
          for (int kip = 0; kip < 2; kip++)
            run_op(wr[0], (len * 5 + kw * 3 + kip) % 40, len, kw, kip, -1, 1'b0, 1'b0);

    // R9 retry at different word indexes
    for (int wr = 0; wr < 2; wr++)
      for (int s = 1; s <= 3; s++)
        run_op(wr[0], 8 + s, 5, s - 1, 0, s, 1'b0, 1'b0);

    // R10 target abort
    run_op(1'b1, 20, 4, 0, 0, -1, 1'b1, 1'b0);
    run_op(1'b0, 21, 4, 1, 0, -1, 1'b1, 1'b0);

    // R11 grant withdrawn mid-burst
    run_op(1'b1, 30, 6, 0, 0, -1, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule